// File: doc/BRIEF.md
# Timer / Event Counter with Single-Shot Pulse Capture

This block is an up-counter with a reload value and three ways to advance. In timer mode it counts ticks of an internal time base. The time base is picked from the system clock, a divide-by-4 of the system clock, or a strobe from a slow oscillator, and is then divided by a power-of-two prescaler. In event mode it counts active edges of an external pin. In capture mode it counts prescaled internal ticks only while the pin sits at its active level. When the pulse ends, the block clears its own run bit, so each arm measures exactly one pulse.

Software writes a control byte and a preload value through two write strobes that share one data bus. It reads back the count and the control byte. When the count rolls over, the counter reloads from the preload value and raises a sticky interrupt flag. The flag is cleared by a strobe. If the core is halted when the overflow happens, the block also gives a single-cycle wake request. All interfaces are plain strobes and levels. There is no streaming data path, so there is no valid/ready handshake and no back-pressure.

Control byte layout:
- bits [7:6]: mode, with 00 = off, 01 = event, 10 = timer, 11 = capture.
- bit 5: reserved, reads 0.
- bit 4: run.
- bit 3: polarity. 0 means the rising edge and the high level are active; 1 means the falling edge and the low level are active.
- bits [2:0]: prescale exponent.

`clk_sel` picks the time base: 00 = system clock, 01 = system clock / 4, 1x = `slow_tick` strobes.

Top module: `tmr_evcnt_cap`

## Requirements
- R1: After reset the count, control byte, interrupt flag and wake request are all 0.
- R2: A preload write while the counter is stopped (run bit 0 or mode 00) loads the count directly. While the counter is running, the write changes only the preload value and the count is unaffected.
- R3: In timer mode (10) with the system clock as time base and exponent p, the count rises by one every 2^p cycles. Measured from the edge that writes the control byte, it equals floor(N/2^p) after N further clock edges.
- R4: `clk_sel` = 01 divides the system clock by 4 ahead of the prescaler. `clk_sel` = 1x counts one base tick per `slow_tick` strobe.
- R5: In event mode (01) the count rises by one per active edge of the synchronized pin, as selected by control bit 3. Edges of the opposite direction are not counted.
- R6: In capture mode (11), with exponent p and the system clock as base, a pulse held active for W cycles adds floor(W/2^p) to the count.
- R7: At the end of the active pulse in capture mode, the run bit (bit 4) clears by itself, and later pin activity leaves the count unchanged.
- R8: When the count is all ones and a tick arrives, the count reloads from the preload value and the interrupt flag sets. `flag_clr` clears the flag; a same-cycle set wins.
- R9: An overflow while `halted` is high gives a one-cycle `wake_req`. Counting goes on while halted. An overflow while not halted gives no wake request.
- R10: In mode 00 the count holds even with the run bit set. Bit 5 of the control byte always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_ctrl | input | 1 | Strobe: write control byte from wr_data[7:0] |
| wr_load | input | 1 | Strobe: write preload value from wr_data |
| wr_data | input | CNT_W | Write data bus |
| clk_sel | input | 2 | Time base select for timer and capture modes |
| slow_tick | input | 1 | One-cycle strobe from the slow oscillator |
| ext_pin | input | 1 | Asynchronous external pin |
| halted | input | 1 | Core is halted |
| flag_clr | input | 1 | Strobe: clear the overflow flag |
| cnt_out | output | CNT_W | Current count |
| ctrl_out | output | 8 | Control byte readback |
| ovf_flag | output | 1 | Sticky overflow interrupt flag |
| wake_req | output | 1 | One-cycle wake request on overflow while halted |

## Verification
The assertions take the write strobes and `flag_clr` as single-cycle pulses. They assume the count moves only by increment, reload or direct load, and that only capture mode can clear the run bit without a software write. The stimulus follows the limits the exact count checks depend on:
- `clk_sel` changes only while the counter is stopped.
- Each pin level is held for at least two clock cycles, so the synchronizer sees every edge.
- `slow_tick` pulses are single cycles with gaps between them.
- Timer trials pick lengths that cannot roll the count over, except in the directed overflow cases.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_OFF     = 2'b00,
    MODE_EVENT   = 2'b01,
    MODE_TIMER   = 2'b10,
    MODE_CAPTURE = 2'b11
  } tmr_mode_e;

  localparam int PS_BITS = 3;

  typedef struct packed {
    tmr_mode_e          mode;
    logic               rsv;
    logic               run;
    logic               pol;
    logic [PS_BITS-1:0] pexp;
  } tmr_ctrl_t;

  localparam int CTRL_W = $bits(tmr_ctrl_t);
endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic pol_i,
  output logic lvl_o,
  output logic act_edge_o,
  output logic trail_edge_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;
  logic              prev_lvl;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= pin_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[STAGES-1];

  assign lvl_o        = chain_q[STAGES-1] ^ pol_i;
  assign prev_lvl     = prev_q ^ pol_i;
  assign act_edge_o   = lvl_o & ~prev_lvl;
  assign trail_edge_o = ~lvl_o & prev_lvl;
endmodule

// File: rtl/tmr_src_div.sv
module tmr_src_div #(
  parameter int PS_BITS = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic               gate_i,
  input  logic [1:0]         clk_sel_i,
  input  logic               slow_tick_i,
  input  logic [PS_BITS-1:0] pexp_i,
  output logic               tick_o
);
  localparam int PRE_W = (1 << PS_BITS) - 1;

  logic [1:0]       div4_q;
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W:0]   span;
  logic [PRE_W:0]   span_m1;
  logic [PRE_W-1:0] mask;
  logic             base_tick;
  logic             adv;

  always_comb begin
    unique case (clk_sel_i)
      2'b00:   base_tick = 1'b1;
      2'b01:   base_tick = (div4_q == 2'd3);
      default: base_tick = slow_tick_i;
    endcase
  end

  assign span    = {{PRE_W{1'b0}}, 1'b1} << pexp_i;
  assign span_m1 = span - 1'b1;
  assign mask    = span_m1[PRE_W-1:0];
  assign adv     = en_i & gate_i & base_tick;
  assign tick_o  = adv & ((pre_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div4_q <= '0;
      pre_q  <= '0;
    end else if (!en_i) begin
      div4_q <= '0;
      pre_q  <= '0;
    end else if (gate_i) begin
      div4_q <= div4_q + 2'd1;
      if (base_tick) pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_load_i,
  input  logic             direct_i,
  input  logic [CNT_W-1:0] data_i,
  input  logic             tick_i,
  input  logic             halted_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o,
  output logic             wake_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload_q;
  logic             flag_q;
  logic             wake_q;
  logic             roll;

  assign roll = tick_i & (cnt_q == '1) & ~direct_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      reload_q <= '0;
      flag_q   <= 1'b0;
      wake_q   <= 1'b0;
    end else begin
      if (wr_load_i) reload_q <= data_i;
      if (direct_i)  cnt_q <= data_i;
      else if (roll) cnt_q <= reload_q;
      else if (tick_i) cnt_q <= cnt_q + 1'b1;
      if (roll)            flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
      wake_q <= roll & halted_i;
    end
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;
  assign wake_o = wake_q;
endmodule

// File: rtl/tmr_evcnt_cap.sv
module tmr_evcnt_cap
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic             wr_load,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       clk_sel,
  input  logic             slow_tick,
  input  logic             ext_pin,
  input  logic             halted,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cnt_out,
  output logic [7:0]       ctrl_out,
  output logic             ovf_flag,
  output logic             wake_req
);
  tmr_ctrl_t ctrl_q;
  tmr_ctrl_t ctrl_wr;
  logic      lvl, act_edge, trail_edge;
  logic      active, timed, src_en, src_gate, src_tick, evt_tick, tick;
  logic      direct;

  assign ctrl_wr = tmr_ctrl_t'({wr_data[7:6], 1'b0, wr_data[4:0]});

  assign active = ctrl_q.run & (ctrl_q.mode != MODE_OFF);
  assign timed  = ctrl_q.run & ((ctrl_q.mode == MODE_TIMER) | (ctrl_q.mode == MODE_CAPTURE));
  assign src_en = timed;
  assign src_gate = (ctrl_q.mode == MODE_CAPTURE) ? lvl : 1'b1;
  assign evt_tick = ctrl_q.run & (ctrl_q.mode == MODE_EVENT) & act_edge;
  assign tick     = src_tick | evt_tick;
  assign direct   = wr_load & ~active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_wr;
    else if (ctrl_q.run && ctrl_q.mode == MODE_CAPTURE && trail_edge) ctrl_q.run <= 1'b0;
  end

  tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(ext_pin), .pol_i(ctrl_q.pol),
    .lvl_o(lvl), .act_edge_o(act_edge), .trail_edge_o(trail_edge)
  );

  tmr_src_div #(.PS_BITS(PS_BITS)) u_div (
    .clk(clk), .rst_n(rst_n), .en_i(src_en), .gate_i(src_gate),
    .clk_sel_i(clk_sel), .slow_tick_i(slow_tick), .pexp_i(ctrl_q.pexp),
    .tick_o(src_tick)
  );

  tmr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .wr_load_i(wr_load), .direct_i(direct),
    .data_i(wr_data), .tick_i(tick), .halted_i(halted), .flag_clr_i(flag_clr),
    .cnt_o(cnt_out), .flag_o(ovf_flag), .wake_o(wake_req)
  );

  assign ctrl_out = ctrl_q;
endmodule

// File: rtl/tmr_evcnt_cap_chk.sv
module tmr_evcnt_cap_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_ctrl,
  input logic             wr_load,
  input logic             halted,
  input logic [CNT_W-1:0] cnt_out,
  input logic [7:0]       ctrl_out,
  input logic             ovf_flag,
  input logic             wake_req
);
  assert_wake_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> $past(halted));

  assert_wake_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> ovf_flag);

  assert_self_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ctrl_out[4]) && !$past(wr_ctrl)) |-> ($past(ctrl_out[7:6]) == 2'b11));

  assert_hold_stopped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ctrl_out[4]) && !$past(wr_load)) |-> $stable(cnt_out));

  assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_out) != '1 && !$past(wr_load) && cnt_out != $past(cnt_out))
      |-> (cnt_out == CNT_W'($past(cnt_out) + 1'b1)));

  assert_roll_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_out) == '1 && cnt_out != '1 && !$past(wr_load)) |-> ovf_flag);
endmodule

bind tmr_evcnt_cap tmr_evcnt_cap_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_load(wr_load),
  .halted(halted), .cnt_out(cnt_out), .ctrl_out(ctrl_out),
  .ovf_flag(ovf_flag), .wake_req(wake_req)
);

// File: tb/tmr_evcnt_cap_test.sv
module tmr_evcnt_cap_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_ctrl = 1'b0, wr_load = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] clk_sel = '0;
  logic       slow_tick = 1'b0, ext_pin = 1'b0, halted = 1'b0, flag_clr = 1'b0;
  logic [7:0] cnt_out, ctrl_out;
  logic       ovf_flag, wake_req;
  int checks = 0, fails = 0, wakes = 0;
  int unsigned seed_val;

  always #4 clk = ~clk;

  tmr_evcnt_cap uut (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_load(wr_load),
    .wr_data(wr_data), .clk_sel(clk_sel), .slow_tick(slow_tick),
    .ext_pin(ext_pin), .halted(halted), .flag_clr(flag_clr),
    .cnt_out(cnt_out), .ctrl_out(ctrl_out), .ovf_flag(ovf_flag),
    .wake_req(wake_req)
  );

  always @(negedge clk) if (rst_n && wake_req) wakes++;

  function automatic int exp_timer(int n, int p, int sel);
    return (sel == 1) ? ((n / 4) >> p) : (n >> p);
  endfunction

  function automatic int exp_capture(int w, int p);
    return w >> p;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrc(logic [7:0] v);
    wr_ctrl = 1'b1; wr_data = v; step(1); wr_ctrl = 1'b0;
  endtask

  task automatic wrl(logic [7:0] v);
    wr_load = 1'b1; wr_data = v; step(1); wr_load = 1'b0;
  endtask

  task automatic edge_pulse(logic act_lvl);
    ext_pin = act_lvl; step(2); ext_pin = ~act_lvl; step(2);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    seed_val = $urandom(32'h5EED_1234);
    step(3); rst_n = 1'b1; step(1);
    // R1 reset state
    chk("R1 count", cnt_out, 0);
    chk("R1 ctrl", ctrl_out, 0);
    chk("R1 flag", ovf_flag, 0);
    chk("R1 wake", wake_req, 0);

    // R3 random timer trials, system clock base
    for (int t = 0; t < 8; t++) begin
      int p = $urandom_range(0, 7);
      int n = $urandom_range(1, 255);
      wrc(8'h00); wrl(8'h00);
      wrc({2'b10, 1'b0, 1'b1, 1'b0, 3'(p)});
      step(n);
      chk("R3 timer count", cnt_out, exp_timer(n, p, 0));
    end

    // R4 divide-by-4 base
    wrc(8'h00); clk_sel = 2'b01; wrl(8'h00);
    wrc({2'b10, 1'b0, 1'b1, 1'b0, 3'd1}); step(40);
    chk("R4 sys/4 count", cnt_out, exp_timer(40, 1, 1));
    // R4 slow strobe base
    wrc(8'h00); clk_sel = 2'b10; wrl(8'h00);
    wrc({2'b10, 1'b0, 1'b1, 1'b0, 3'd0}); step(5);
    for (int k = 0; k < 7; k++) begin
      slow_tick = 1'b1; step(1); slow_tick = 1'b0; step(3);
    end
    chk("R4 slow count", cnt_out, 7);
    wrc(8'h00); clk_sel = 2'b00;

    // R2 direct load while stopped, preload-only while running
    wrl(8'h5A);
    chk("R2 direct load", cnt_out, 8'h5A);
    ext_pin = 1'b0; step(4);
    wrc({2'b01, 1'b0, 1'b1, 1'b0, 3'd0});
    wrl(8'h11); step(3);
    chk("R2 load while running", cnt_out, 8'h5A);

    // R5 random event trials
    for (int t = 0; t < 6; t++) begin
      logic pol = 1'($urandom_range(0, 1));
      int k = $urandom_range(1, 20);
      wrc(8'h00); ext_pin = pol; step(4); wrl(8'h00);
      wrc({2'b01, 1'b0, 1'b1, pol, 3'd0});
      for (int e = 0; e < k; e++) edge_pulse(~pol);
      step(4);
      chk("R5 event count", cnt_out, k);
    end
    // R5 opposite edge ignored
    wrc(8'h00); ext_pin = 1'b0; step(4); wrl(8'h00);
    wrc({2'b01, 1'b0, 1'b1, 1'b1, 3'd0});
    ext_pin = 1'b1; step(5);
    chk("R5 rising ignored in falling polarity", cnt_out, 0);
    ext_pin = 1'b0; step(5);
    chk("R5 falling counted", cnt_out, 1);

    // R6 / R7 random capture trials
    for (int t = 0; t < 6; t++) begin
      logic pol = 1'($urandom_range(0, 1));
      int p = $urandom_range(0, 3);
      int w = $urandom_range(2, 120);
      wrc(8'h00); ext_pin = pol; step(4); wrl(8'h00);
      wrc({2'b11, 1'b0, 1'b1, pol, 3'(p)}); step(2);
      ext_pin = ~pol; step(w); ext_pin = pol; step(5);
      chk("R6 capture width", cnt_out, exp_capture(w, p));
      chk("R7 run bit cleared", ctrl_out[4], 0);
      ext_pin = ~pol; step(10); ext_pin = pol; step(5);
      chk("R7 second pulse ignored", cnt_out, exp_capture(w, p));
    end

    // R8 overflow, reload and flag
    wrc(8'h00); wrl(8'hF0);
    wrc({2'b10, 1'b0, 1'b1, 1'b0, 3'd0}); step(16);
    chk("R8 reload value", cnt_out, 8'hF0);
    chk("R8 flag set", ovf_flag, 1);
    chk("R9 no wake when awake", wakes, 0);
    wrc(8'h00);
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
    chk("R8 flag cleared", ovf_flag, 0);

    // R9 wake on overflow while halted, event counting continues
    ext_pin = 1'b0; step(4); wrl(8'hFE);
    halted = 1'b1;
    wrc({2'b01, 1'b0, 1'b1, 1'b0, 3'd0});
    edge_pulse(1'b1);
    chk("R9 counts while halted", cnt_out, 8'hFF);
    edge_pulse(1'b1); step(2);
    chk("R9 reload while halted", cnt_out, 8'hFE);
    chk("R9 wake pulse", wakes, 1);
    chk("R9 flag with wake", ovf_flag, 1);
    halted = 1'b0;

    // R10 mode off holds, reserved bit reads zero
    wrc(8'h00); wrl(8'h33);
    wrc({2'b00, 1'b0, 1'b1, 1'b0, 3'd0}); step(20);
    chk("R10 mode off holds", cnt_out, 8'h33);
    wrl(8'h44);
    chk("R10 mode off direct load", cnt_out, 8'h44);
    wrc(8'hFF);
    chk("R10 reserved bit", ctrl_out, 8'hDF);
    wrc(8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule